// File: doc/BRIEF.md
# Buffered Flash Programming Engine

The block is a host-side sequencer that writes a run of words into a parallel NOR-type flash using that device's buffered program command. A caller hands it a start offset, a word count and a data source. The source is either a plain array port indexed by position in the run, or a short pattern of M words that repeats across the run. The engine first checks that the range lies inside the device. It then reads every target word to confirm that it is still erased.

Next it cuts the range into pieces that never cross a 16-word buffer boundary. For each piece it issues the command cycles, then polls the device status word under a poll-count timeout. It decodes the error flags with a fixed priority. Last, it puts the device back into read-array mode.

All device traffic goes through a single request/acknowledge bus-master port. The outcome comes back as a 3-bit result code with a one-cycle done strobe.

Top module: `flash_buf_prog`

## Requirements
- R1: After reset, busy_o, done_o and bus_req_o are low and result_o is 0 (success).
- R2: A start with length 0, or with offset+length-1 at or above DEV_WORDS, makes no bus transfer and finishes with result 1 (address invalid).
- R3: Before any write, every word from offset to offset+length-1 is read in ascending order. The first word that is not all ones ends the operation at once with result 2 (already programmed), with no write.
- R4: Each piece runs from the current offset to the smaller of (current offset OR BUF_WORDS-1) and the last offset. Its count word equals its last offset minus its first offset, and the next piece starts one past its end.
- R5: For each piece the writes are, in order: 0050h, E8h and the count word at the piece's first offset; then the data words at ascending offsets; then 00D0h at the first offset. Status reads follow, also at the first offset.
- R6: With pattern length 0, the data word for the k-th word of the run (k from 0 across the whole run) comes from src_idx_o = k. With pattern length M>0 it comes from src_idx_o = k mod M.
- R7: Status is read until bit 7 is 1. After TIMEOUT_POLLS consecutive reads with bit 7 low, the engine writes 00FFh to address 0 and finishes with result 6 (timeout), with no further transfer.
- R8: A ready status is decoded with this priority: bit 3 gives result 3, then bit 1 gives result 4, then bit 5 or bit 4 gives result 5. Any error ends the loop over pieces.
- R9: After the last piece, or after a decoded error, the engine writes 0050h and then 00FFh to address 0 before finishing. A clean run gives result 0.
- R10: A transfer is held (req, we, addr, wdata unchanged) until bus_ack_i is sampled high; it completes in that cycle. Read data is taken from bus_rdata_i in the same cycle.
- R11: done_o is high for one cycle per operation with busy_o low. result_o changes only in a cycle where done_o is high, and holds between strobes.
- R12: start_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| offset_i | input | AW | First word offset |
| length_i | input | AW+1 | Number of words |
| pat_len_i | input | PAT_W | Pattern length M, 0 selects array mode |
| src_idx_o | output | AW | Index into the caller's data source |
| src_data_i | input | DW | Data word at src_idx_o (combinational) |
| bus_req_o | output | 1 | Transfer request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | AW | Word address |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Transfer acknowledge |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 3 | Result code of the last operation |

## Verification
The assertions assume that the responder never drops a request it has not acknowledged, and that src_data_i depends only on src_idx_o, so that write data stays steady during a held transfer. The bench keeps to both rules. It acknowledges each request exactly once, with a rotating latency of zero to two cycles. It drives src_data_i from a fixed table indexed by src_idx_o. Starts are given only while idle, except in the one case that deliberately pokes start_i during a busy run. Pattern lengths stay below 2^PAT_W.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  typedef enum logic [2:0] {
    RES_OK     = 3'd0,
    RES_ADDR   = 3'd1,
    RES_DOUBLE = 3'd2,
    RES_VPP    = 3'd3,
    RES_PROT   = 3'd4,
    RES_PFAIL  = 3'd5,
    RES_TMO    = 3'd6
  } res_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_CLR, S_SETUP, S_CNT, S_DATA,
    S_CONF, S_POLL, S_TRST, S_FCLR, S_FRA
  } st_e;

  localparam logic [7:0] CMD_CLR   = 8'h50;
  localparam logic [7:0] CMD_SETUP = 8'hE8;
  localparam logic [7:0] CMD_CONF  = 8'hD0;
  localparam logic [7:0] CMD_RA    = 8'hFF;

  localparam int SB_RDY  = 7;
  localparam int SB_ERS  = 5;
  localparam int SB_PRG  = 4;
  localparam int SB_VPP  = 3;
  localparam int SB_PROT = 1;
endpackage

// File: rtl/fpe_chunk.sv
module fpe_chunk #(
  parameter int AW        = 8,
  parameter int BUF_WORDS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          chk_en_i,
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] last_i,
  output logic [AW-1:0] end_o
);
  localparam int BB = $clog2(BUF_WORDS);
  localparam logic [AW-1:0] MASK = AW'(BUF_WORDS - 1);

  logic [AW-1:0] lim;
  assign lim   = cur_i | MASK;
  assign end_o = (lim > last_i) ? last_i : lim;

  // R4: a piece never leaves the buffer it starts in
  a_r4_piece_in_buffer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_en_i |-> (end_o >= cur_i) && ((end_o >> BB) == (cur_i >> BB)));
endmodule

// File: rtl/fpe_pattern.sv
module fpe_pattern #(
  parameter int AW    = 8,
  parameter int PAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [PAT_W-1:0] pat_len_i,
  input  logic             adv_i,
  output logic [AW-1:0]    idx_o
);
  logic [AW-1:0]    k_q;
  logic [PAT_W-1:0] m_q, pat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q   <= '0;
      m_q   <= '0;
      pat_q <= '0;
    end else if (clr_i) begin
      k_q   <= '0;
      m_q   <= '0;
      pat_q <= pat_len_i;
    end else if (adv_i) begin
      k_q <= k_q + 1'b1;
      m_q <= (pat_q != '0 && m_q == pat_q - 1'b1) ? '0 : m_q + 1'b1;
    end
  end

  assign idx_o = (pat_q == '0) ? k_q : AW'(m_q);

  // R6: repeat index stays inside the pattern
  a_r6_idx_in_pattern: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_q != '0 |-> m_q < pat_q);
endmodule

// File: rtl/fpe_decode.sv
module fpe_decode
  import fpe_pkg::*;
(
  input  logic [7:0] status_i,
  output logic       err_o,
  output logic [2:0] code_o
);
  always_comb begin
    err_o  = 1'b1;
    code_o = RES_OK;
    if (status_i[SB_VPP])                         code_o = RES_VPP;
    else if (status_i[SB_PROT])                   code_o = RES_PROT;
    else if (status_i[SB_ERS] || status_i[SB_PRG]) code_o = RES_PFAIL;
    else                                          err_o  = 1'b0;
  end
endmodule

// File: rtl/flash_buf_prog.sv
module flash_buf_prog
  import fpe_pkg::*;
#(
  parameter int DEV_WORDS     = 256,
  parameter int DW            = 16,
  parameter int BUF_WORDS     = 16,
  parameter int PAT_W         = 4,
  parameter int TIMEOUT_POLLS = 1000,
  localparam int AW = $clog2(DEV_WORDS),
  localparam int LW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    offset_i,
  input  logic [LW-1:0]    length_i,
  input  logic [PAT_W-1:0] pat_len_i,
  output logic [AW-1:0]    src_idx_o,
  input  logic [DW-1:0]    src_data_i,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [DW-1:0]    bus_wdata_o,
  input  logic [DW-1:0]    bus_rdata_i,
  input  logic             bus_ack_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       result_o
);
  localparam int TW = $clog2(TIMEOUT_POLLS + 1);

  st_e           state;
  logic [AW-1:0] cur, last, first, base, cend, chunk_end;
  logic [TW-1:0] pcnt;
  logic [2:0]    pend, res_q;
  logic          done_q;
  logic          derr;
  logic [2:0]    dcode;
  logic [AW+1:0] last_wide;
  logic          range_bad;

  assign last_wide = {2'b00, offset_i} + {1'b0, length_i} - 1'b1;
  assign range_bad = (length_i == '0) || (last_wide >= (AW+2)'(DEV_WORDS));

  fpe_chunk #(.AW(AW), .BUF_WORDS(BUF_WORDS)) u_chunk (
    .clk_i, .rst_ni,
    .chk_en_i (state == S_CLR),
    .cur_i    (cur),
    .last_i   (last),
    .end_o    (chunk_end)
  );

  fpe_pattern #(.AW(AW), .PAT_W(PAT_W)) u_pat (
    .clk_i, .rst_ni,
    .clr_i     (state == S_IDLE && start_i),
    .pat_len_i (pat_len_i),
    .adv_i     (state == S_DATA && bus_ack_i),
    .idx_o     (src_idx_o)
  );

  fpe_decode u_dec (
    .status_i (bus_rdata_i[7:0]),
    .err_o    (derr),
    .code_o   (dcode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= S_IDLE;
      cur    <= '0;
      last   <= '0;
      first  <= '0;
      base   <= '0;
      cend   <= '0;
      pcnt   <= '0;
      pend   <= RES_OK;
      res_q  <= RES_OK;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: if (start_i) begin
          if (range_bad) begin
            res_q  <= RES_ADDR;
            done_q <= 1'b1;
          end else begin
            cur   <= offset_i;
            first <= offset_i;
            last  <= last_wide[AW-1:0];
            state <= S_PRE;
          end
        end
        S_PRE: if (bus_ack_i) begin
          if (bus_rdata_i != '1) begin
            res_q  <= RES_DOUBLE;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else if (cur == last) begin
            cur   <= first;
            state <= S_CLR;
          end else begin
            cur <= cur + 1'b1;
          end
        end
        S_CLR: if (bus_ack_i) begin
          base  <= cur;
          cend  <= chunk_end;
          state <= S_SETUP;
        end
        S_SETUP: if (bus_ack_i) state <= S_CNT;
        S_CNT:   if (bus_ack_i) state <= S_DATA;
        S_DATA: if (bus_ack_i) begin
          cur <= cur + 1'b1;
          if (cur == cend) state <= S_CONF;
        end
        S_CONF: if (bus_ack_i) begin
          pcnt  <= '0;
          state <= S_POLL;
        end
        S_POLL: if (bus_ack_i) begin
          if (bus_rdata_i[SB_RDY]) begin
            if (derr) begin
              pend  <= dcode;
              state <= S_FCLR;
            end else if (cend == last) begin
              pend  <= RES_OK;
              state <= S_FCLR;
            end else begin
              state <= S_CLR;
            end
          end else if (pcnt == TW'(TIMEOUT_POLLS - 1)) begin
            state <= S_TRST;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        S_TRST: if (bus_ack_i) begin
          res_q  <= RES_TMO;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        S_FCLR: if (bus_ack_i) state <= S_FRA;
        S_FRA: if (bus_ack_i) begin
          res_q  <= pend;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req_o   = 1'b1;
    bus_we_o    = 1'b1;
    bus_addr_o  = base;
    bus_wdata_o = '0;
    unique case (state)
      S_IDLE: begin
        bus_req_o  = 1'b0;
        bus_we_o   = 1'b0;
        bus_addr_o = '0;
      end
      S_PRE: begin
        bus_we_o   = 1'b0;
        bus_addr_o = cur;
      end
      S_CLR: begin
        bus_addr_o  = cur;
        bus_wdata_o = DW'(CMD_CLR);
      end
      S_SETUP: bus_wdata_o = DW'(CMD_SETUP);
      S_CNT:   bus_wdata_o = DW'(cend - base);
      S_DATA: begin
        bus_addr_o  = cur;
        bus_wdata_o = src_data_i;
      end
      S_CONF: bus_wdata_o = DW'(CMD_CONF);
      S_POLL: bus_we_o = 1'b0;
      S_TRST, S_FRA: begin
        bus_addr_o  = '0;
        bus_wdata_o = DW'(CMD_RA);
      end
      S_FCLR: begin
        bus_addr_o  = '0;
        bus_wdata_o = DW'(CMD_CLR);
      end
      default: bus_req_o = 1'b0;
    endcase
  end

  assign busy_o   = (state != S_IDLE);
  assign done_o   = done_q;
  assign result_o = res_q;

  // R10: a pending transfer is held until acknowledged
  a_r10_bus_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_we_o)
                              && $stable(bus_addr_o) && $stable(bus_wdata_o));

  // R11: result moves only with the strobe
  a_r11_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  // R11: strobe only when idle
  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7: poll count never passes its limit
  a_r7_poll_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == S_POLL |-> int'(pcnt) < TIMEOUT_POLLS);
endmodule

// File: tb/sim_flash_buf_prog.sv
module sim_flash_buf_prog;
  localparam int DEV = 256;
  localparam int AW  = 8;
  localparam int DW  = 16;
  localparam int TO  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start = 1'b0;
  logic [AW-1:0] off = '0;
  logic [AW:0]   len = '0;
  logic [3:0]    pat = '0;
  logic [AW-1:0] src_idx;
  logic [DW-1:0] src_data;
  logic          req, we, ack = 1'b0;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata = '0;
  logic          busy, done;
  logic [2:0]    result;

  logic [15:0] src [DEV];
  logic [15:0] fl  [DEV];
  int busy_n [16];
  int fin_st [16];

  assign src_data = src[src_idx];

  flash_buf_prog #(.DEV_WORDS(DEV), .DW(DW), .BUF_WORDS(16), .PAT_W(4),
                   .TIMEOUT_POLLS(TO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .offset_i(off), .length_i(len),
    .pat_len_i(pat), .src_idx_o(src_idx), .src_data_i(src_data),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_rdata_i(rdata), .bus_ack_i(ack), .busy_o(busy), .done_o(done),
    .result_o(result));

  typedef struct { bit w; int a; logic [15:0] d; string tag; } txn_t;
  txn_t exp_q[$];

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input bit w, input int a, input logic [15:0] d, input string tag);
    txn_t t;
    t.w = w; t.a = a; t.d = d; t.tag = tag;
    exp_q.push_back(t);
  endtask

  // device-side responder and per-cycle hold check
  int  wait_cnt = 0, lat = 0;
  bit  pend = 0;
  logic p_we; logic [AW-1:0] p_addr; logic [DW-1:0] p_wd;
  always @(negedge clk) begin
    if (pend)
      chk(req && we == p_we && addr == p_addr && wdata == p_wd, "R10 hold",
          {req, we, addr, wdata}, {1'b1, p_we, p_addr, p_wd});
    if (ack) begin
      ack = 1'b0;
    end else if (req) begin
      if (wait_cnt < lat) wait_cnt++;
      else begin
        txn_t e;
        if (exp_q.size() == 0) begin
          chk(0, "R5 unexpected transfer", {we, addr, wdata}, 0);
        end else begin
          e = exp_q.pop_front();
          chk(we == e.w && int'(addr) == e.a && (!e.w || wdata == e.d),
              e.tag, {we, addr, wdata}, {e.w, 8'(e.a), (e.w ? e.d : wdata)});
          rdata = e.w ? 16'h0 : e.d;
        end
        ack = 1'b1; wait_cnt = 0; lat = (lat + 1) % 3;
      end
    end
    pend = req && !ack;
    p_we = we; p_addr = addr; p_wd = wdata;
  end

  task automatic build(input int o, input int l, input int m, output int res);
    int last, cur, k, ch, e;
    logic [15:0] s;
    exp_q.delete();
    res  = 0;
    last = o + l - 1;
    if (l == 0 || last >= DEV) begin res = 1; return; end
    for (int a = o; a <= last; a++) begin
      push(0, a, fl[a], "R3 pre-read");
      if (fl[a] != 16'hFFFF) begin res = 2; return; end
    end
    cur = o; k = 0; ch = 0;
    forever begin
      e = cur | 15;
      if (e > last) e = last;
      push(1, cur, 16'h0050, "R5 clear");
      push(1, cur, 16'h00E8, "R5 setup");
      push(1, cur, 16'(e - cur), "R4 count");
      for (int a = cur; a <= e; a++) begin
        push(1, a, src[(m == 0) ? k : (k % m)], "R6 data");
        k++;
      end
      push(1, cur, 16'h00D0, "R5 confirm");
      if (busy_n[ch] >= TO) begin
        for (int i = 0; i < TO; i++) push(0, cur, 16'h0000, "R7 poll");
        push(1, 0, 16'h00FF, "R7 reset");
        res = 6;
        return;
      end
      for (int i = 0; i < busy_n[ch]; i++) push(0, cur, 16'h0000, "R7 poll");
      s = 16'(fin_st[ch]) | 16'h0080;
      push(0, cur, s, "R7 ready");
      if (s[3]) res = 3;
      else if (s[1]) res = 4;
      else if (s[5] || s[4]) res = 5;
      if (res != 0 || e == last) break;
      cur = e + 1; ch++;
    end
    push(1, 0, 16'h0050, "R9 clear");
    push(1, 0, 16'h00FF, "R9 read-array");
  endtask

  task automatic run_op(input int o, input int l, input int m, input string tag,
                        input bit poke);
    int er, cnt;
    logic [2:0] r;
    build(o, l, m, er);
    @(negedge clk);
    start = 1'b1; off = AW'(o); len = (AW+1)'(l); pat = 4'(m);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R12 busy", busy, 1);
      start = 1'b1; off = 8'd200; len = 9'd3; pat = 4'd0;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && cnt < 5000) begin @(negedge clk); cnt++; end
    chk(done == 1'b1, {tag, " done"}, done, 1);
    chk(result == 3'(er), {tag, " result"}, result, er);
    chk(exp_q.size() == 0, {tag, " transfers left"}, exp_q.size(), 0);
    r = result;
    @(negedge clk);
    chk(!done && !busy, "R11 single strobe", {done, busy}, 0);
    repeat (2) @(negedge clk);
    chk(result == r, "R11 result held", result, r);
    for (int i = 0; i < 16; i++) begin busy_n[i] = 0; fin_st[i] = 0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEV; i++) begin src[i] = 16'hA000 + 16'(i * 7); fl[i] = 16'hFFFF; end
    for (int i = 0; i < 16; i++) begin busy_n[i] = 0; fin_st[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req && result == 0, "R1 reset", {busy, done, req, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !req && result == 0, "R1 after release", {busy, done, req, result}, 0);

    run_op(250, 7, 0, "R2 past end", 0);
    run_op(10, 0, 0, "R2 zero length", 0);
    run_op(0, 4, 0, "R9 four words", 0);
    run_op(8, 16, 0, "R4 two pieces", 0);
    busy_n[1] = 3;
    run_op(5, 40, 3, "R6 repeat three", 0);
    run_op(0, 16, 15, "R6 repeat fifteen", 0);
    run_op(250, 6, 2, "R4 device end", 0);
    fl[30] = 16'h1234;
    run_op(28, 5, 0, "R3 dirty word", 0);
    fl[30] = 16'hFFFF;
    fin_st[0] = 'h1A;
    run_op(0, 20, 0, "R8 vpp first", 0);
    fin_st[0] = 'h32;
    run_op(0, 20, 0, "R8 protect next", 0);
    fin_st[0] = 'h20;
    run_op(64, 4, 0, "R8 sequence fail", 0);
    fin_st[0] = 'h10;
    run_op(16, 4, 0, "R8 program fail", 0);
    fin_st[1] = 'h02;
    run_op(12, 8, 0, "R8 second piece", 0);
    busy_n[0] = TO;
    run_op(40, 3, 0, "R7 timeout", 0);
    busy_n[0] = TO - 1;
    run_op(40, 3, 0, "R7 last poll", 0);
    run_op(100, 20, 0, "R12 restart ignored", 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule